// File: doc/BRIEF.md
# H-Bridge Gate Controller with Per-Leg Fault Latch

This block is the digital control core of a full H-bridge motor driver. Two direction inputs choose one of four bridge modes: drive one way, drive the other way, brake to supply or brake to ground. A PWM input modulates only the low-side switches. Each half-bridge leg has an open-drain enable/diagnostic line. The block samples that line as an enable and pulls it low to report a fault. The block drives four gate-enable outputs, a high-side and a low-side gate for leg A and for leg B.

Analog comparators supply single-bit flags to the block. Per leg there is a high-side overtemperature flag and a low-side saturation flag; saturation means the output is shorted to supply. A supply undervoltage flag and a supply overvoltage flag are shared by both legs.

- A leg fault latches that leg off until its direction input rises while the fault is absent.
- A supply fault turns every switch off only while the flag is present.
- A new direction setting must stay stable for a programmable number of cycles before it is applied.
- Every external input passes through a two-flop synchronizer.
- A one-cycle all-off gap separates the high-side and low-side conduction of a leg.

Top module: `hbridge_ctrl`

## Requirements
- R1: While reset is asserted and right after it, all four gates are off and both pull-down outputs are inactive.
- R2: With both enable lines high and PWM high, direction inputs (dir_a, dir_b) map as follows. 11 turns on both high sides. 10 turns on high side A and low side B. 01 turns on low side A and high side B. 00 turns on both low sides.
- R3: While PWM is low, both low-side gates are off and high-side gates follow the direction inputs unchanged. When PWM returns high, the selected low sides turn back on.
- R4: An enable line sampled low turns off both gates of that leg only.
- R5: A high-side overtemperature flag on a leg latches that leg. Its gates go off and its pull-down output asserts, while the other leg keeps running. A qualified saturation flag on a leg does the same.
- R6: A latched leg is released only by a low-to-high transition of its direction input seen while its fault flag is clear. A rising edge while the fault persists, or the fault going away with no edge, leaves the latch set.
- R7: A saturation flag counts only once that leg's low-side gate has been on without a break for SAT_BLANK cycles. A shorter assertion after a PWM-low gap raises no fault.
- R8: A direction change takes effect only after the new value has been stable for MODE_DLY cycles. A change that reverts sooner has no effect on the gates.
- R9: An undervoltage or overvoltage flag turns all four gates off without setting any latch. The bridge resumes its previous mode once the flag clears.
- R10: The high-side and low-side gates of a leg are never on in the same cycle. A gate that was on is followed by at least one cycle with the other gate off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| dir_a | input | 1 | Leg A direction: 1 selects high side, 0 low side |
| dir_b | input | 1 | Leg B direction: 1 selects high side, 0 low side |
| pwm_in | input | 1 | PWM; low forces both low sides off |
| diag_a_i | input | 1 | Sampled level of leg A enable/diagnostic line |
| diag_b_i | input | 1 | Sampled level of leg B enable/diagnostic line |
| ot_a | input | 1 | Leg A high-side overtemperature flag |
| ot_b | input | 1 | Leg B high-side overtemperature flag |
| sat_a | input | 1 | Leg A low-side saturation flag |
| sat_b | input | 1 | Leg B low-side saturation flag |
| uv_flag | input | 1 | Supply undervoltage flag |
| ov_flag | input | 1 | Supply overvoltage flag |
| diag_a_pd | output | 1 | Pull-down enable for leg A line (fault report) |
| diag_b_pd | output | 1 | Pull-down enable for leg B line (fault report) |
| hs_a | output | 1 | Leg A high-side gate |
| ls_a | output | 1 | Leg A low-side gate |
| hs_b | output | 1 | Leg B high-side gate |
| ls_b | output | 1 | Leg B low-side gate |

## Verification
A corrupted fault latch shows at the ports within four cycles of the flag. The pull-down asserts and the leg's gates drop, or else the leg stays dark after a valid release edge. A wrong mode-delay count shows up as gates that switch early or never switch. Probes are placed both halfway through the delay window and after it. A broken break-before-make state or blanking counter shows up cycle by cycle. A gate overlap appears on the gate pins, and a false saturation latch appears on the pull-down output a few cycles after the low side turns back on.

// File: rtl/hbc_pkg.sv
package hbc_pkg;
  typedef enum logic [1:0] {
    SW_OFF = 2'd0,
    SW_HS  = 2'd1,
    SW_LS  = 2'd2
  } sw_e;

  localparam int unsigned NUM_LEGS = 2;
endpackage

// File: rtl/hbc_sync.sv
module hbc_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/hbc_mode_delay.sv
module hbc_mode_delay #(
  parameter int unsigned WIDTH    = 2,
  parameter int unsigned MODE_DLY = 120000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] req_i,
  output logic [WIDTH-1:0] applied_o
);
  localparam int unsigned CW    = $clog2(MODE_DLY + 1);
  localparam logic [CW-1:0] LAST = CW'(MODE_DLY - 1);

  logic [WIDTH-1:0] req_q, req_d;
  logic [WIDTH-1:0] app_q, app_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    req_d  = req_i;
    app_d  = app_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b1;
    if (req_i == app_q) begin
      cnt_d = '0;
    end else if (req_i != req_q) begin
      cnt_d = '0;
    end else if (cnt_q == LAST) begin
      app_d = req_i;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      app_q <= '0;
      cnt_q <= '0;
    end else if (cnt_en) begin
      req_q <= req_d;
      app_q <= app_d;
      cnt_q <= cnt_d;
    end
  end

  assign applied_o = app_q;

  // R8
  fresh_change_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i != req_q) |=> $stable(app_q));
endmodule

// File: rtl/hbc_leg.sv
module hbc_leg
  import hbc_pkg::*;
#(
  parameter int unsigned SAT_BLANK = 1200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dir_s,
  input  logic dir_cmd,
  input  logic pwm_s,
  input  logic line_s,
  input  logic ot_s,
  input  logic sat_s,
  input  logic supply_ok,
  output logic gate_hs,
  output logic gate_ls,
  output logic pull_dn
);
  localparam int unsigned BW = $clog2(SAT_BLANK + 1);
  localparam logic [BW-1:0] BLANK_MAX = BW'(SAT_BLANK);

  sw_e           cur_q, cur_d, target;
  logic          latch_q, latch_d;
  logic          dir_q;
  logic [BW-1:0] blank_q, blank_d;
  logic          leg_en, sat_hit, fault_now, dir_rise;

  always_comb begin
    leg_en    = line_s & ~latch_q;
    sat_hit   = sat_s & (cur_q == SW_LS) & (blank_q == BLANK_MAX);
    fault_now = ot_s | sat_hit;
    dir_rise  = dir_s & ~dir_q;

    latch_d = latch_q;
    if (fault_now)     latch_d = 1'b1;
    else if (dir_rise) latch_d = 1'b0;

    if (!supply_ok || latch_q || !leg_en) target = SW_OFF;
    else if (dir_cmd)                     target = SW_HS;
    else if (pwm_s)                       target = SW_LS;
    else                                  target = SW_OFF;

    if (cur_q != SW_OFF && target != cur_q) cur_d = SW_OFF;
    else                                    cur_d = target;

    if (cur_q != SW_LS)             blank_d = '0;
    else if (blank_q != BLANK_MAX)  blank_d = blank_q + 1'b1;
    else                            blank_d = blank_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= SW_OFF;
      latch_q <= 1'b0;
      dir_q   <= 1'b0;
      blank_q <= '0;
    end else begin
      cur_q   <= cur_d;
      latch_q <= latch_d;
      dir_q   <= dir_s;
      blank_q <= blank_d;
    end
  end

  assign gate_hs = (cur_q == SW_HS);
  assign gate_ls = (cur_q == SW_LS);
  assign pull_dn = latch_q;

  // R10
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hs && gate_ls));
  // R10
  hs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_hs |=> !gate_ls);
  // R10
  ls_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_ls |=> !gate_hs);
  // R5
  latched_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pull_dn |=> (!gate_hs && !gate_ls));
  // R9
  supply_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (!gate_hs && !gate_ls));
  // R6
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && !(dir_s && !dir_q)) |=> latch_q);
endmodule

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl
  import hbc_pkg::*;
#(
  parameter int unsigned MODE_DLY    = 120000,
  parameter int unsigned SAT_BLANK   = 1200,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dir_a,
  input  logic dir_b,
  input  logic pwm_in,
  input  logic diag_a_i,
  input  logic diag_b_i,
  input  logic ot_a,
  input  logic ot_b,
  input  logic sat_a,
  input  logic sat_b,
  input  logic uv_flag,
  input  logic ov_flag,
  output logic diag_a_pd,
  output logic diag_b_pd,
  output logic hs_a,
  output logic ls_a,
  output logic hs_b,
  output logic ls_b
);
  localparam int unsigned NIN = 5 * NUM_LEGS + 1;

  logic [NIN-1:0]      raw_in, syn_in;
  logic [NUM_LEGS-1:0] dir_s, line_s, ot_s, sat_s, dir_cmd;
  logic [NUM_LEGS-1:0] hs_v, ls_v, pd_v;
  logic                pwm_s, supply_ok;

  assign raw_in = {ov_flag, uv_flag, sat_b, sat_a, ot_b, ot_a,
                   diag_b_i, diag_a_i, pwm_in, dir_b, dir_a};

  hbc_sync #(.WIDTH(NIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_in), .q_o(syn_in)
  );

  assign dir_s     = syn_in[1:0];
  assign pwm_s     = syn_in[2];
  assign line_s    = syn_in[4:3];
  assign ot_s      = syn_in[6:5];
  assign sat_s     = syn_in[8:7];
  assign supply_ok = ~(syn_in[9] | syn_in[10]);

  hbc_mode_delay #(.WIDTH(NUM_LEGS), .MODE_DLY(MODE_DLY)) u_delay (
    .clk(clk), .rst_n(rst_n), .req_i(dir_s), .applied_o(dir_cmd)
  );

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    hbc_leg #(.SAT_BLANK(SAT_BLANK)) u_leg (
      .clk      (clk),
      .rst_n    (rst_n),
      .dir_s    (dir_s[g]),
      .dir_cmd  (dir_cmd[g]),
      .pwm_s    (pwm_s),
      .line_s   (line_s[g]),
      .ot_s     (ot_s[g]),
      .sat_s    (sat_s[g]),
      .supply_ok(supply_ok),
      .gate_hs  (hs_v[g]),
      .gate_ls  (ls_v[g]),
      .pull_dn  (pd_v[g])
    );
  end

  assign hs_a      = hs_v[0];
  assign ls_a      = ls_v[0];
  assign hs_b      = hs_v[1];
  assign ls_b      = ls_v[1];
  assign diag_a_pd = pd_v[0];
  assign diag_b_pd = pd_v[1];
endmodule

// File: tb/hbridge_ctrl_test.sv
module hbridge_ctrl_test;
  localparam int MODE_DLY  = 20;
  localparam int SAT_BLANK = 16;
  localparam int SETTLE    = MODE_DLY + 12;
  localparam int WD_LIMIT  = 100000;

  // [8] dir_a [7] dir_b [6] pwm [5] en_a [4] en_b [3:0] {hs_a,ls_a,hs_b,ls_b}
  localparam logic [8:0] VECS [0:8] = '{
    9'b11_1_11_1010,
    9'b10_1_11_1001,
    9'b01_1_11_0110,
    9'b00_1_11_0101,
    9'b00_0_11_0000,
    9'b10_0_11_1000,
    9'b10_1_01_0001,
    9'b01_1_10_0100,
    9'b11_1_00_0000
  };

  logic clk = 1'b0;
  logic rst_n;
  logic dir_a, dir_b, pwm_in, diag_a_i, diag_b_i;
  logic ot_a, ot_b, sat_a, sat_b, uv_flag, ov_flag;
  logic diag_a_pd, diag_b_pd, hs_a, ls_a, hs_b, ls_b;

  int tests = 0;
  int fails = 0;
  int wd    = 0;
  int overlap_bad = 0;
  logic p_hs_a = 1'b0, p_ls_a = 1'b0, p_hs_b = 1'b0, p_ls_b = 1'b0;

  always #2.5 clk = ~clk;

  hbridge_ctrl #(.MODE_DLY(MODE_DLY), .SAT_BLANK(SAT_BLANK)) uut (
    .clk(clk), .rst_n(rst_n), .dir_a(dir_a), .dir_b(dir_b), .pwm_in(pwm_in),
    .diag_a_i(diag_a_i), .diag_b_i(diag_b_i), .ot_a(ot_a), .ot_b(ot_b),
    .sat_a(sat_a), .sat_b(sat_b), .uv_flag(uv_flag), .ov_flag(ov_flag),
    .diag_a_pd(diag_a_pd), .diag_b_pd(diag_b_pd),
    .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b), .ls_b(ls_b)
  );

  // R10 cycle monitor: overlap or missing off-gap between sides of one leg
  always @(negedge clk) begin
    if (rst_n) begin
      if ((hs_a && ls_a) || (hs_b && ls_b)) overlap_bad++;
      if ((p_hs_a && ls_a) || (p_ls_a && hs_a)) overlap_bad++;
      if ((p_hs_b && ls_b) || (p_ls_b && hs_b)) overlap_bad++;
    end
    p_hs_a <= hs_a; p_ls_a <= ls_a; p_hs_b <= hs_b; p_ls_b <= ls_b;
  end

  always @(posedge clk) begin
    wd++;
    if (wd > WD_LIMIT) begin
      fails++;
      $display("FAIL watchdog expired: actual %0d cycles expected below %0d", wd, WD_LIMIT);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act[3:0], exp[3:0]);
    end
  endtask

  function automatic int gates();
    return {28'd0, hs_a, ls_a, hs_b, ls_b};
  endfunction

  function automatic int pds();
    return {30'd0, diag_a_pd, diag_b_pd};
  endfunction

  initial begin
    rst_n = 1'b0;
    dir_a = 1'b0; dir_b = 1'b0; pwm_in = 1'b0;
    diag_a_i = 1'b1; diag_b_i = 1'b1;
    ot_a = 1'b0; ot_b = 1'b0; sat_a = 1'b0; sat_b = 1'b0;
    uv_flag = 1'b0; ov_flag = 1'b0;
    wait_cyc(4);
    check("R1 gates in reset", gates(), 0);
    check("R1 pull-downs in reset", pds(), 0);
    rst_n = 1'b1;
    wait_cyc(2);
    check("R1 gates after reset", gates(), 0);

    // R2 R3 R4 vector table
    for (int v = 0; v < 9; v++) begin
      dir_a = VECS[v][8]; dir_b = VECS[v][7]; pwm_in = VECS[v][6];
      diag_a_i = VECS[v][5]; diag_b_i = VECS[v][4];
      wait_cyc(SETTLE);
      check($sformatf("R2 R3 R4 vector %0d", v), gates(), int'(VECS[v][3:0]));
    end

    // R8 mode delay: start from both low sides on
    dir_a = 1'b0; dir_b = 1'b0; pwm_in = 1'b1; diag_a_i = 1'b1; diag_b_i = 1'b1;
    wait_cyc(SETTLE);
    dir_a = 1'b1;
    wait_cyc(MODE_DLY / 2);
    check("R8 not applied inside window", gates(), 4'b0101);
    dir_a = 1'b0;
    wait_cyc(SETTLE);
    check("R8 short change ignored", gates(), 4'b0101);
    dir_a = 1'b1;
    wait_cyc(SETTLE);
    check("R8 applied after window", gates(), 4'b1001);

    // R5 R6 overtemperature on leg A while driving A high, B low
    ot_a = 1'b1;
    wait_cyc(6);
    check("R5 leg A latched, B runs", gates(), 4'b0001);
    check("R5 pull-down A", pds(), 2'b10);
    dir_a = 1'b0; wait_cyc(5); dir_a = 1'b1; wait_cyc(5);
    check("R6 edge with fault present keeps latch", pds(), 2'b10);
    ot_a = 1'b0;
    wait_cyc(10);
    check("R6 fault gone without edge keeps latch", gates(), 4'b0001);
    dir_a = 1'b0; wait_cyc(5); dir_a = 1'b1;
    wait_cyc(SETTLE);
    check("R6 released by rising edge", pds(), 2'b00);
    check("R6 leg A drives again", gates(), 4'b1001);

    // R7 saturation blanking on leg B low side
    pwm_in = 1'b0;
    wait_cyc(6);
    check("R3 PWM low drops low side B", gates(), 4'b1000);
    sat_b = 1'b1; pwm_in = 1'b1;
    wait_cyc(8);
    sat_b = 1'b0;
    wait_cyc(30);
    check("R7 short saturation ignored", pds(), 2'b00);
    check("R7 low side B still on", gates(), 4'b1001);
    sat_b = 1'b1;
    wait_cyc(30);
    check("R5 saturation latches B", pds(), 2'b01);
    check("R5 leg B off after saturation", gates(), 4'b1000);
    sat_b = 1'b0;
    dir_b = 1'b1;
    wait_cyc(SETTLE);
    check("R6 leg B released by its edge", pds(), 2'b00);
    check("R6 mode 11 after release", gates(), 4'b1010);
    dir_b = 1'b0;
    wait_cyc(SETTLE);

    // R9 supply flags
    uv_flag = 1'b1;
    wait_cyc(6);
    check("R9 undervoltage all off", gates(), 0);
    check("R9 undervoltage not latched", pds(), 0);
    uv_flag = 1'b0;
    wait_cyc(6);
    check("R9 resume after undervoltage", gates(), 4'b1001);
    ov_flag = 1'b1;
    wait_cyc(6);
    check("R9 overvoltage all off", gates(), 0);
    ov_flag = 1'b0;
    wait_cyc(6);
    check("R9 resume after overvoltage", gates(), 4'b1001);

    check("R10 no overlap and gap kept", overlap_bad, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule